// File: doc/BRIEF.md
# DMA Control Register and Command Decoder

This block holds the programmable state of a four-channel DMA controller and decodes the CPU's register accesses. The CPU port is an 8-bit data bus with a 4-bit register address and separate single-cycle read and write strobes. Some addresses hold data. Others are pure commands, where only the address and the strobe matter.

The block keeps the following state:
- the command register
- the latched terminal-count flags and the software request bits
- the temporary byte for memory-to-memory moves
- per-channel mask bits
- the byte-pointer flip-flop
- one mode byte per channel, with a read pointer

An optional 16-bit transfer mode adds one data-width bit per channel. The transfer engine reads all of this state from dedicated outputs. The engine returns three things to the block: terminal-count pulses, the last word it moved, and an idle indication. The idle indication tells the block when a deferred exit from 16-bit mode may take effect.

Register codes, used only when addr[3] = 1:

| addr[2:0] | write | read |
|---|---|---|
| 0 | command | status |
| 1 | request | command |
| 2 | single mask/width bit | request |
| 3 | mode byte | mode byte at pointer |
| 4 | byte-pointer flip-flop | temporary |
| 5 | clear all masks | mask/width |
| 6 | master clear | clear mode pointer |
| 7 | all mask/width bits | none (returns 0) |

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, mask_o is all ones. cmd_o, swreq_o, width_o, ff_o and mode_ptr_o are zero, and wide_o is 0.
- R2: dout is zero whenever rd_en is low. Any strobe with addr[3] = 0 has no effect on any state and reads as zero.
- R3: A write to code 0 loads cmd_o with din, and a read of code 1 returns it. A command write with din[7] = 1 enters 16-bit mode (wide_o = 1).
- R4: A write to code 1 sets swreq_o[din[1:0]] to din[2]. A read of code 2 returns {4'b0, swreq}.
- R5: A tc_in pulse on a channel latches that channel's flag. A read of code 0 returns {swreq, flags}, then clears the flags.
- R6: A write to code 2 selects channel din[1:0] and value din[2]. With din[3] = 0 it writes that channel's mask bit. With din[3] = 1 it writes that channel's width bit, but only in 16-bit mode; outside 16-bit mode this write changes nothing.
- R7: A write to code 7 loads the mask bits from din[3:0]. It loads the width bits from din[7:4] only in 16-bit mode.
- R8: A read of code 5 returns {width bits, mask bits}.
- R9: A write to code 5 clears all mask bits and leaves every width bit unchanged.
- R10: A write to code 6 (master clear) sets all mask bits. It clears the command, request, flags, temporary, byte pointer and mode pointer. If 16-bit mode is active, it remains active until a cycle with eng_idle = 1. On that cycle wide_o and all width bits clear.
- R11: When tmp_load is high, the temporary register captures tmp_data[7:0]. A read of code 4 returns the held byte until the next master clear or reset.
- R12: A write to code 4 sets ff_o to din[0].
- R13: A write to code 3 stores din into the mode byte of channel din[1:0]. Each read of code 3 returns the byte at mode_ptr_o, then advances the pointer modulo 4. A read of code 6 returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| din | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| dout | output | 8 | CPU read data, zero when not reading |
| tc_in | input | 4 | Terminal-count pulse per channel |
| tmp_load | input | 1 | Capture tmp_data into temporary register |
| tmp_data | input | 16 | Last word moved memory-to-memory |
| eng_idle | input | 1 | Transfer engine is in an idle cycle |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| width_o | output | 4 | Channel data-width bits |
| wide_o | output | 1 | 16-bit transfer mode active |
| swreq_o | output | 4 | Software request bits |
| ff_o | output | 1 | Byte-pointer flip-flop |
| mode_ptr_o | output | 2 | Mode read pointer |
| mode_o | output | 32 | Mode bytes, channel n at bits 8n+7:8n |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit data bus and a 16-bit temporary input. With these values the select and value bits of the single-bit write land on din[3] and din[2], and the combined mask/width read fills the whole byte. This makes every field position in the requirements observable at dout. The bench also wraps the four-entry mode pointer. It holds eng_idle low across a master clear, so the deferred exit from 16-bit mode is seen to wait and then take effect.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  typedef struct packed {
    logic wr_cmd;
    logic wr_req;
    logic wr_single;
    logic wr_mode;
    logic wr_ff;
    logic wr_clrmask;
    logic wr_mclr;
    logic wr_all;
    logic rd_status;
    logic rd_mode;
    logic rd_clrptr;
    logic rd_hit;
  } dma_ops_t;

  localparam logic [2:0] OP_C0 = 3'd0;
  localparam logic [2:0] OP_C1 = 3'd1;
  localparam logic [2:0] OP_C2 = 3'd2;
  localparam logic [2:0] OP_C3 = 3'd3;
  localparam logic [2:0] OP_C4 = 3'd4;
  localparam logic [2:0] OP_C5 = 3'd5;
  localparam logic [2:0] OP_C6 = 3'd6;
  localparam logic [2:0] OP_C7 = 3'd7;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_ctl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  output logic [2:0]      sel,
  output dma_ops_t        ops
);
  logic hit;
  logic wr, rd;

  assign hit = addr[AW-1];
  assign sel = addr[2:0];
  assign wr  = hit & wr_en;
  assign rd  = hit & rd_en;

  always_comb begin
    ops            = '0;
    ops.rd_hit     = rd;
    ops.wr_cmd     = wr && (sel == OP_C0);
    ops.wr_req     = wr && (sel == OP_C1);
    ops.wr_single  = wr && (sel == OP_C2);
    ops.wr_mode    = wr && (sel == OP_C3);
    ops.wr_ff      = wr && (sel == OP_C4);
    ops.wr_clrmask = wr && (sel == OP_C5);
    ops.wr_mclr    = wr && (sel == OP_C6);
    ops.wr_all     = wr && (sel == OP_C7);
    ops.rd_status  = rd && (sel == OP_C0);
    ops.rd_mode    = rd && (sel == OP_C3);
    ops.rd_clrptr  = rd && (sel == OP_C6);
  end
endmodule

// File: rtl/dma_chan_bits.sv
module dma_chan_bits
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  dma_ops_t       ops,
  input  logic [DW-1:0]  din,
  input  logic           wide,
  input  logic           wide_exit,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] width
);
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int VALB = CW;
  localparam int SELB = CW + 1;

  logic [CW-1:0] ch;
  assign ch = din[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '1;
      width <= '0;
    end else begin
      if (ops.wr_mclr)
        mask <= '1;
      else if (ops.wr_clrmask)
        mask <= '0;
      else if (ops.wr_all)
        mask <= din[NCH-1:0];
      else if (ops.wr_single && !din[SELB])
        mask[ch] <= din[VALB];

      if (wide_exit)
        width <= '0;
      else if (wide && ops.wr_all)
        width <= din[2*NCH-1:NCH];
      else if (wide && ops.wr_single && din[SELB])
        width[ch] <= din[VALB];
    end
  end
endmodule

// File: rtl/dma_mode_bank.sv
module dma_mode_bank #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic              clr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     rdata,
  output logic [$clog2(NCH)-1:0] ptr,
  output logic [NCH*DW-1:0] flat
);
  localparam int CW = $clog2(NCH);

  logic [DW-1:0] mode_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst)
        mode_q[g] <= '0;
      else if (wr && din[CW-1:0] == CW'(g))
        mode_q[g] <= din;
    end
    assign flat[g*DW +: DW] = mode_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      ptr <= '0;
    else if (rd)
      ptr <= (ptr == CW'(NCH-1)) ? '0 : ptr + 1'b1;
  end

  assign rdata = mode_q[ptr];
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int TW  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          din,
  input  logic                   rd_en,
  input  logic                   wr_en,
  output logic [DW-1:0]          dout,
  input  logic [NCH-1:0]         tc_in,
  input  logic                   tmp_load,
  input  logic [TW-1:0]          tmp_data,
  input  logic                   eng_idle,
  output logic [DW-1:0]          cmd_o,
  output logic [NCH-1:0]         mask_o,
  output logic [NCH-1:0]         width_o,
  output logic                   wide_o,
  output logic [NCH-1:0]         swreq_o,
  output logic                   ff_o,
  output logic [$clog2(NCH)-1:0] mode_ptr_o,
  output logic [NCH*DW-1:0]      mode_o
);
  localparam int CW      = $clog2(NCH);
  localparam int VALB    = CW;
  localparam int WIDE_EN = DW - 1;

  dma_ops_t      ops;
  logic [2:0]    sel;
  logic [NCH-1:0] tc_q;
  logic [DW-1:0] tmp_q;
  logic          pend_q;
  logic          wide_exit;
  logic [DW-1:0] mode_rd;
  logic [DW-1:0] rdata;

  dma_cmd_decode #(.AW(AW)) u_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .sel(sel), .ops(ops)
  );

  assign wide_exit = pend_q & eng_idle;

  dma_chan_bits #(.NCH(NCH), .DW(DW)) u_bits (
    .clk(clk), .rst(rst), .ops(ops), .din(din),
    .wide(wide_o), .wide_exit(wide_exit),
    .mask(mask_o), .width(width_o)
  );

  dma_mode_bank #(.NCH(NCH), .DW(DW)) u_mode (
    .clk(clk), .rst(rst), .wr(ops.wr_mode), .rd(ops.rd_mode),
    .clr(ops.rd_clrptr | ops.wr_mclr), .din(din),
    .rdata(mode_rd), .ptr(mode_ptr_o), .flat(mode_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o   <= '0;
      swreq_o <= '0;
      tc_q    <= '0;
      tmp_q   <= '0;
      ff_o    <= 1'b0;
      wide_o  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wide_exit) begin
        wide_o <= 1'b0;
        pend_q <= 1'b0;
      end
      if (ops.wr_mclr) begin
        cmd_o   <= '0;
        swreq_o <= '0;
        tc_q    <= '0;
        tmp_q   <= '0;
        ff_o    <= 1'b0;
        pend_q  <= wide_o & ~wide_exit;
      end else begin
        if (ops.wr_cmd) begin
          cmd_o <= din;
          if (din[WIDE_EN]) begin
            wide_o <= 1'b1;
            pend_q <= 1'b0;
          end
        end
        if (ops.wr_req)
          swreq_o[din[CW-1:0]] <= din[VALB];
        tc_q <= (ops.rd_status ? '0 : tc_q) | tc_in;
        if (tmp_load)
          tmp_q <= tmp_data[DW-1:0];
        if (ops.wr_ff)
          ff_o <= din[0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      OP_C0:   rdata = DW'({swreq_o, tc_q});
      OP_C1:   rdata = cmd_o;
      OP_C2:   rdata = DW'(swreq_o);
      OP_C3:   rdata = mode_rd;
      OP_C4:   rdata = tmp_q;
      OP_C5:   rdata = DW'({width_o, mask_o});
      default: rdata = '0;
    endcase
  end

  assign dout = ops.rd_hit ? rdata : '0;
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          din,
  input logic                   rd_en,
  input logic                   wr_en,
  input logic [DW-1:0]          dout,
  input logic                   eng_idle,
  input logic [DW-1:0]          cmd_o,
  input logic [NCH-1:0]         mask_o,
  input logic [NCH-1:0]         width_o,
  input logic                   wide_o,
  input logic [NCH-1:0]         swreq_o,
  input logic                   ff_o,
  input logic [$clog2(NCH)-1:0] mode_ptr_o
);
  logic w_mclr, w_clrmask, w_ff;
  assign w_mclr    = wr_en && addr[AW-1] && addr[2:0] == 3'd6;
  assign w_clrmask = wr_en && addr[AW-1] && addr[2:0] == 3'd5;
  assign w_ff      = wr_en && addr[AW-1] && addr[2:0] == 3'd4;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mask_o == '1 && !wide_o && cmd_o == '0)); // R1
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> dout == '0); // R2
  AST_NARROW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    !wide_o |-> width_o == '0); // R6
  AST_CLRMASK_KEEPS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    w_clrmask |=> (mask_o == '0 && (!$stable(wide_o) || $stable(width_o)))); // R9
  AST_MCLR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    w_mclr |=> (mask_o == '1 && cmd_o == '0 && swreq_o == '0 && !ff_o && mode_ptr_o == '0)); // R10
  AST_WIDE_HELD: assert property (@(posedge clk) disable iff (rst)
    wide_o && !eng_idle |=> wide_o); // R10
  AST_FF_WRITE: assert property (@(posedge clk) disable iff (rst)
    w_ff |=> ff_o == $past(din[0])); // R12
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .din(din), .rd_en(rd_en), .wr_en(wr_en),
  .dout(dout), .eng_idle(eng_idle), .cmd_o(cmd_o), .mask_o(mask_o),
  .width_o(width_o), .wide_o(wide_o), .swreq_o(swreq_o), .ff_o(ff_o),
  .mode_ptr_o(mode_ptr_o)
);

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  din = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  dout;
  logic [3:0]  tc_in = '0;
  logic        tmp_load = 1'b0;
  logic [15:0] tmp_data = '0;
  logic        eng_idle = 1'b1;
  logic [7:0]  cmd_o;
  logic [3:0]  mask_o, width_o, swreq_o;
  logic        wide_o, ff_o;
  logic [1:0]  mode_ptr_o;
  logic [31:0] mode_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dma_ctl_regs u_dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .rd_en(rd_en), .wr_en(wr_en),
    .dout(dout), .tc_in(tc_in), .tmp_load(tmp_load), .tmp_data(tmp_data),
    .eng_idle(eng_idle), .cmd_o(cmd_o), .mask_o(mask_o), .width_o(width_o),
    .wide_o(wide_o), .swreq_o(swreq_o), .ff_o(ff_o), .mode_ptr_o(mode_ptr_o),
    .mode_o(mode_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = '0; din = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #5 v = dout;
    @(negedge clk); rd_en = 1'b0; addr = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mask", mask_o, 4'hF);
    chk("R1 wide", wide_o, 0);
    chk("R1 cmd", cmd_o, 0);
    chk("R1 width/req/ff/ptr", {width_o, swreq_o, ff_o, mode_ptr_o}, 0);
    chk("R2 dout idle", dout, 0);
  endtask

  task automatic t_addr_gate;
    logic [7:0] v;
    wr(4'h0, 8'h85);
    chk("R2 low addr write ignored", {cmd_o, wide_o}, 0);
    wr(4'h5, 8'h00);
    chk("R2 low addr clear-mask ignored", mask_o, 4'hF);
    rd(4'h1, v);
    chk("R2 low addr read", v, 0);
  endtask

  task automatic t_cmd_req;
    logic [7:0] v;
    wr(4'h8, 8'h5A);
    chk("R3 cmd_o", cmd_o, 8'h5A);
    chk("R3 no wide", wide_o, 0);
    rd(4'h9, v);
    chk("R3 read cmd", v, 8'h5A);
    wr(4'h9, 8'h06);
    wr(4'h9, 8'h05);
    chk("R4 swreq", swreq_o, 4'b0110);
    wr(4'h9, 8'h01);
    chk("R4 swreq clear ch1", swreq_o, 4'b0100);
    wr(4'h9, 8'h05);
    rd(4'hA, v);
    chk("R4 read request", v, 8'h06);
  endtask

  task automatic t_status;
    logic [7:0] v;
    @(negedge clk); tc_in = 4'b1001;
    @(negedge clk); tc_in = 4'b0000;
    rd(4'h8, v);
    chk("R5 status flags", v, 8'h69);
    rd(4'h8, v);
    chk("R5 flags cleared", v, 8'h60);
  endtask

  task automatic t_mask_narrow;
    logic [7:0] v;
    wr(4'hA, 8'h01);
    chk("R6 single mask", mask_o, 4'b1101);
    wr(4'hA, 8'h0C);
    chk("R6 width ignored narrow", {width_o, mask_o}, 8'h0D);
    rd(4'hD, v);
    chk("R8 combined narrow", v, 8'h0D);
    wr(4'hF, 8'hA3);
    chk("R7 all narrow", {width_o, mask_o}, 8'h03);
  endtask

  task automatic t_wide;
    logic [7:0] v;
    wr(4'h8, 8'h80);
    chk("R3 enter wide", wide_o, 1);
    wr(4'hA, 8'h0D);
    chk("R6 width single", {width_o, mask_o}, 8'h23);
    wr(4'hF, 8'h5A);
    chk("R7 all wide", {width_o, mask_o}, 8'h5A);
    rd(4'hD, v);
    chk("R8 combined wide", v, 8'h5A);
    wr(4'hD, 8'h00);
    chk("R9 clear mask", {width_o, mask_o}, 8'h50);
  endtask

  task automatic t_temp_ff_mclr;
    logic [7:0] v;
    @(negedge clk); tmp_load = 1'b1; tmp_data = 16'hBEEF;
    @(negedge clk); tmp_load = 1'b0; tmp_data = 16'h1234;
    repeat (3) @(negedge clk);
    rd(4'hC, v);
    chk("R11 temp low byte held", v, 8'hEF);
    wr(4'hC, 8'h01);
    chk("R12 ff set", ff_o, 1);
    wr(4'hC, 8'h00);
    chk("R12 ff clear", ff_o, 0);
    wr(4'hC, 8'h01);
    wr(4'h9, 8'h07);
    eng_idle = 1'b0;
    wr(4'hE, 8'h00);
    chk("R10 mclr regs", {cmd_o, swreq_o, ff_o}, 0);
    chk("R10 mclr mask", mask_o, 4'hF);
    chk("R10 wide kept", {wide_o, width_o}, 5'h15);
    rd(4'hC, v);
    chk("R11 temp cleared", v, 0);
    repeat (4) @(negedge clk);
    chk("R10 wide held busy", wide_o, 1);
    eng_idle = 1'b1;
    @(negedge clk);
    chk("R10 wide exit at idle", {wide_o, width_o}, 0);
  endtask

  task automatic t_mode;
    logic [7:0] v;
    wr(4'hB, 8'h40); wr(4'hB, 8'h41); wr(4'hB, 8'h42); wr(4'hB, 8'h43);
    chk("R13 mode_o", mode_o, 32'h43424140);
    for (int i = 0; i < 5; i++) begin
      rd(4'hB, v);
      chk("R13 mode read seq", v, 8'h40 + (i % 4));
    end
    chk("R13 ptr after wrap", mode_ptr_o, 1);
    rd(4'hE, v);
    chk("R13 ptr cleared", mode_ptr_o, 0);
    rd(4'hB, v);
    chk("R13 read after clear", v, 8'h40);
  endtask

  initial begin
    t_reset();
    t_addr_gate();
    t_cmd_req();
    t_status();
    t_mask_narrow();
    t_wide();
    t_temp_ff_mclr();
    t_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule